// File: doc/BRIEF.md
# Claim Tag Set/Clear Register

This block keeps a small set of claim tags. Debug agents use them to mark that some piece of debug function is in use. Each tag is one flop. One 64-bit register port reaches the tags through two windows, and a separate select line picks each window.

- **Setting window.** Writing a one to a bit sets that tag. Reading this window reports which tag positions exist, never the state of the tags.
- **Clearing window.** Writing a one to a bit clears that tag. Reading this window reports the live tag state.

Writing a zero through either window leaves the tag alone. The parameter `NUM_TAGS` sets the number of tags, from 1 to 32. Positions at or above that count, and the whole upper 32-bit half of the register, read as zero and ignore writes.

Reads are combinational from the current state. A write takes effect at the rising clock edge on which `wr_en` is high. Access permission is decided elsewhere, so this block does no privilege checking. The current tags are also driven out in parallel, so neighbouring logic can see them without a register read.

Top module: `claim_tag_reg`

## Requirements
- R1: While `rst_n` is low, every tag is 0. After reset, `tags_o` is 0 and a clearing-window read returns 0.
- R2: With only `sel_set` high, `rdata` equals the implemented mask. Bits 0 to NUM_TAGS-1 are 1 and all other bits are 0, so with four or more tags bits [3:0] read 4'b1111.
- R3: A write with only `sel_set` high sets tag m when `wdata[m]` is 1. Tags whose data bit is 0 keep their value.
- R4: A write with `sel_clr` high clears tag m when `wdata[m]` is 1. Tags whose data bit is 0 keep their value.
- R5: With only `sel_clr` high, `rdata` equals the tag state, zero-extended to 64 bits.
- R6: `rdata` bits at index NUM_TAGS and above always read 0, including bits [63:32]. Write data in those positions changes no tag in either window.
- R7: A write with both selects high applies the same data to both windows, and clearing wins. Every tag whose data bit is 1 ends at 0, and the other tags keep their value.
- R8: No tag changes in a cycle where `wr_en` is low, or where neither select is high. With neither select high, `rdata` is 0.
- R9: A `NUM_TAGS` outside the range 1 to 32 stops elaboration with an error.
- R10: A read with both selects high returns the bitwise OR of the two windows, which equals the implemented mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_set | input | 1 | Selects the setting window |
| sel_clr | input | 1 | Selects the clearing window |
| wr_en | input | 1 | Write strobe for the selected window(s) |
| wdata | input | 64 | Write data, one bit per tag position |
| rdata | output | 64 | Combinational read data of the selected window(s) |
| tags_o | output | NUM_TAGS | Current tag state |

## Verification
The bench uses five tags so it can sweep every starting tag state against every low-bit write pattern through both windows. Upper data bits are random, which catches a design that lets high bits leak into tags or read data. A design that returns tag state through the setting window, or writes the whole field instead of only its ones, breaks the or-into or and-not result expected for that pair. Writes with both selects high check that clearing wins, since a set-priority design would leave those bits at 1. Idle cycles with data present, and writes with no select, expose a design that decodes the strobe or the selects too loosely.

// File: rtl/claim_pkg.sv
package claim_pkg;
   localparam int REG_W    = 64;
   localparam int MAX_TAGS = 32;

   // Read value of the setting window: one per implemented position
   function automatic logic [REG_W-1:0] impl_mask(input int n);
      logic [REG_W-1:0] m;
      m = '0;
      for (int i = 0; i < MAX_TAGS; i++) begin
         if (i < n) m[i] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/claim_tag_cell.sv
module claim_tag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= 1'b0;
      else if (clr_i) q <= 1'b0;   // clearing has priority
      else if (set_i) q <= 1'b1;
   end
endmodule

// File: rtl/claim_tag_bank.sv
module claim_tag_bank #(
   parameter int NUM_TAGS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_TAGS-1:0] set_req,
   input  logic [NUM_TAGS-1:0] clr_req,
   output logic [NUM_TAGS-1:0] tags
);
   for (genvar g = 0; g < NUM_TAGS; g++) begin : g_cell
      claim_tag_cell cell_i (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (set_req[g]),
         .clr_i (clr_req[g]),
         .q     (tags[g])
      );
   end
endmodule

// File: rtl/claim_read_mux.sv
module claim_read_mux
   import claim_pkg::*;
#(
   parameter int NUM_TAGS = 8
) (
   input  logic                sel_set,
   input  logic                sel_clr,
   input  logic [NUM_TAGS-1:0] tags,
   output logic [REG_W-1:0]    rdata
);
   localparam logic [REG_W-1:0] MASK = impl_mask(NUM_TAGS);
   localparam int PAD_W = REG_W - NUM_TAGS;

   logic [REG_W-1:0] state_view;
   assign state_view = {{PAD_W{1'b0}}, tags};

   always_comb begin
      rdata = '0;
      if (sel_set) rdata = rdata | MASK;
      if (sel_clr) rdata = rdata | state_view;
   end
endmodule

// File: rtl/claim_tag_reg.sv
module claim_tag_reg
   import claim_pkg::*;
#(
   parameter int NUM_TAGS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sel_set,
   input  logic                sel_clr,
   input  logic                wr_en,
   input  logic [63:0]         wdata,
   output logic [63:0]         rdata,
   output logic [NUM_TAGS-1:0] tags_o
);
   // R9: configuration range check at elaboration
   if (NUM_TAGS < 1 || NUM_TAGS > MAX_TAGS) begin : g_bad_cfg
      $error("claim_tag_reg: NUM_TAGS must lie in 1..32");
   end

   logic                wr_set, wr_clr;
   logic [NUM_TAGS-1:0] set_req, clr_req;
   logic                unused_wdata_hi;

   assign wr_set  = wr_en & sel_set;
   assign wr_clr  = wr_en & sel_clr;
   assign set_req = {NUM_TAGS{wr_set}} & wdata[NUM_TAGS-1:0];
   assign clr_req = {NUM_TAGS{wr_clr}} & wdata[NUM_TAGS-1:0];
   assign unused_wdata_hi = ^wdata[REG_W-1:NUM_TAGS];

   claim_tag_bank #(.NUM_TAGS(NUM_TAGS)) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (set_req),
      .clr_req (clr_req),
      .tags    (tags_o)
   );

   claim_read_mux #(.NUM_TAGS(NUM_TAGS)) rmux_i (
      .sel_set (sel_set),
      .sel_clr (sel_clr),
      .tags    (tags_o),
      .rdata   (rdata)
   );
endmodule

// File: rtl/claim_tag_reg_chk.sv
module claim_tag_reg_chk #(
   parameter int NUM_TAGS = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sel_set,
   input logic                sel_clr,
   input logic                wr_en,
   input logic [63:0]         wdata,
   input logic [63:0]         rdata,
   input logic [NUM_TAGS-1:0] tags_o
);
   logic [63:0] lo_mask;
   always_comb begin
      lo_mask = '0;
      for (int i = 0; i < NUM_TAGS; i++) lo_mask[i] = 1'b1;
   end

   logic [NUM_TAGS-1:0] wlo;
   assign wlo = NUM_TAGS'(wdata & lo_mask);

   a_r1_reset_zero: assert property (@(posedge clk)
      !rst_n |=> tags_o == '0);

   a_r2_set_view_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_set && !sel_clr) |-> rdata == lo_mask);

   a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel_set && !sel_clr) |=> (tags_o & $past(wlo)) == $past(wlo));

   a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel_clr) |=> (tags_o & $past(wlo)) == '0);

   a_r5_clr_view_state: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_clr && !sel_set) |-> rdata == 64'(tags_o));

   a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata & ~lo_mask) == '0);

   a_r6_high_data_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      ((wdata & lo_mask) == '0) |=> $stable(tags_o));

   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || (!sel_set && !sel_clr)) |=> $stable(tags_o));
endmodule

bind claim_tag_reg claim_tag_reg_chk #(.NUM_TAGS(NUM_TAGS)) chk_i (.*);

// File: tb/claim_tag_reg_tb_top.sv
module claim_tag_reg_tb_top;
   localparam int N = 5;
   localparam logic [63:0] MASK = 64'h1F;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_set = 1'b0, sel_clr = 1'b0, wr_en = 1'b0;
   logic [63:0] wdata = '0;
   logic [63:0] rdata;
   logic [N-1:0] tags_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [N-1:0] model = '0;

   always #2 clk = ~clk;   // 250 MHz

   claim_tag_reg #(.NUM_TAGS(N)) dut_i (.*);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] noise();
      return {$urandom, $urandom} & ~MASK;
   endfunction

   task automatic wr(input logic s, input logic c, input logic e, input logic [63:0] d);
      @(negedge clk);
      sel_set = s; sel_clr = c; wr_en = e; wdata = d;
      @(negedge clk);
      sel_set = 0; sel_clr = 0; wr_en = 0; wdata = '0;
   endtask

   task automatic rd(input logic s, input logic c, output logic [63:0] v);
      sel_set = s; sel_clr = c;
      #1 v = rdata;
      sel_set = 0; sel_clr = 0;
   endtask

   task automatic load(input logic [N-1:0] st);
      wr(0, 1, 1, MASK | noise());
      wr(1, 0, 1, 64'(st) | noise());
      model = st;
   endtask

   initial begin : stim
      logic [63:0] v;
      repeat (3) @(negedge clk);
      chk("R1 tags in reset", 64'(tags_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 tags after reset", 64'(tags_o), 0);
      rd(0, 1, v); chk("R1 clear view after reset", v, 0);
      rd(1, 0, v); chk("R2 set view mask", v, MASK);
      rd(0, 0, v); chk("R8 no select reads zero", v, 0);

      for (int s = 0; s < 32; s++) begin
         for (int p = 0; p < 32; p++) begin
            load(N'(s));
            wr(1, 0, 1, 64'(p) | noise());
            model = N'(s) | N'(p);
            rd(0, 1, v); chk("R3 set write", v, 64'(model));
            rd(1, 0, v); chk("R2 set view ignores state", v, MASK);
            load(N'(s));
            wr(0, 1, 1, 64'(p) | noise());
            model = N'(s) & ~N'(p);
            rd(0, 1, v); chk("R4 clear write / R5 clear view", v, 64'(model));
            chk("R5 tags_o matches", 64'(tags_o), 64'(model));
         end
      end

      for (int s = 0; s < 32; s += 3) begin
         load(N'(s));
         wr(1, 1, 1, 64'(N'(s ^ 5'h0A)) | noise());
         model = N'(s) & ~N'(s ^ 5'h0A);
         rd(0, 1, v); chk("R7 clear wins on both selects", v, 64'(model));
         rd(1, 1, v); chk("R10 both selects read OR", v, MASK);
         wr(1, 0, 1, noise() | 64'h8000_0000_0000_0020);
         rd(0, 1, v); chk("R6 high set data ignored", v, 64'(model));
         wr(0, 1, 1, noise() | 64'hFFFF_FFFF_FFFF_FFE0);
         rd(0, 1, v); chk("R6 high clear data ignored", v, 64'(model));
         wr(1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
         rd(0, 1, v); chk("R8 wr_en low holds", v, 64'(model));
         wr(0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
         rd(0, 1, v); chk("R8 no select holds", v, 64'(model));
      end

      load(5'h1F);
      rd(1, 0, v); chk("R6 set view upper zero", v & ~MASK, 0);
      rd(0, 1, v); chk("R6 clear view upper zero", v & ~MASK, 0);
      @(negedge clk);
      rst_n = 1'b0;
      #1 chk("R1 async reset clears", 64'(tags_o), 0);
      @(negedge clk);
      rst_n = 1'b1;
      done = 1'b1;
   end

   initial begin : finish_ctl
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule